// File: doc/BRIEF.md
# Interrupt Pending and Arbitration Unit

This block samples a bank of level-sensitive interrupt request lines into a pending register and masks that register with a locally held enable configuration. It also decides, on each clock, whether an interrupt may be taken. A take is allowed only while the global enable is set and the core is not in debug mode. When a take happens, the block names the winning line and computes the address the core jumps to. That address is the exception entry base plus a per-line offset. The offset is the line's code (a fixed external-interrupt code base plus the line index) multiplied by a configurable vector spacing.

Only the low request lines are wired into the pending register. The enable mask and the spacing are held in a small configuration register that a single load strobe updates and that reset clears. The take indication is a one-cycle pulse. The winning index and the vector address are registered on the same edge and stay put until the next take. The core uses the pulse to start its exception entry, and uses the raw request flag to wake from a low-power wait.

Top module: `irq_arbiter_top`

## Requirements
- R1: On every rising clock edge outside reset, bit i of `pend_bits` takes the level of `req_lines[i]` for i = 0 to 12, so the pending field shows the line levels one cycle late.
- R2: `req_lines` bits 13 to 15 are out of range and have no effect on `pend_bits`, `raw_req`, `take_pulse`, `win_idx` or `vec_addr`.
- R3: `raw_req` is 1 exactly when any bit of `pend_bits` is 1, whatever the enable mask, global enable or debug flag.
- R4: `take_pulse` can rise only if, at the edge that registers it, `glb_ie` was 1 and `dbg_mode` was 0.
- R5: `take_pulse` can rise only if, at that edge, the bitwise AND of the pending field and the enable mask was nonzero.
- R6: `take_pulse` is high for exactly one cycle after the edge at which the take condition (R4 and R5 together) goes from false to true. It does not fire again until the condition has been false at some edge.
- R7: When several masked pending bits are set, `win_idx` is the highest-numbered one.
- R8: `vec_addr` equals `entry_base + (64 + win_idx) * spacing`, computed modulo 2^64 and registered on the same edge as `take_pulse`. `vec_addr` and `win_idx` do not change except on an edge that raises `take_pulse`.
- R9: Synchronous active-high `rst` clears the pending field, the enable mask, the spacing, `take_pulse`, `win_idx` and `vec_addr` to 0.
- R10: When `cfg_load` is 1 at a rising edge, the enable mask takes `cfg_mask` and the spacing takes `cfg_space`. Otherwise both hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lines | input | 16 | Level request lines; bits 13..15 ignored |
| glb_ie | input | 1 | Global interrupt enable |
| dbg_mode | input | 1 | Debug mode flag; blocks takes when 1 |
| cfg_load | input | 1 | Load strobe for mask and spacing |
| cfg_mask | input | 13 | Enable mask value to load |
| cfg_space | input | 8 | Vector spacing value to load |
| entry_base | input | 64 | Exception entry base address |
| pend_bits | output | 13 | Pending field |
| raw_req | output | 1 | Any pending bit set, unmasked |
| take_pulse | output | 1 | One-cycle take strobe |
| win_idx | output | 4 | Winning line index |
| vec_addr | output | 64 | Vector target address |

## Verification
The bench targets the upper request bits 13 to 15, which a design that sliced the input wrongly would let into the pending field or the arbitration. It holds the take condition high for many cycles: a level-driven strobe would stay high instead of pulsing once. It enables several lines at once to catch a lowest-first priority encoder, and it gates the take with debug mode alone, global enable alone and a mask that covers no pending line. A block that treated debug mode as a don't-care, or arbitrated on unmasked bits, would fire there. It also chooses a base and spacing that wrap the 64-bit sum and resets the block in mid-run to show the mask returns to 0, which a truncated adder or a reset that skips the configuration would get wrong.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned IRQ_LINES     = 13;
    localparam int unsigned IRQ_IN_W      = 16;
    localparam int unsigned IRQ_ADDR_W    = 64;
    localparam int unsigned IRQ_SPACE_W   = 8;
    localparam int unsigned IRQ_CODE_BASE = 64;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_FIRED = 1'b1
    } arb_state_e;

    function automatic logic [IRQ_ADDR_W-1:0] vec_target(
        input logic [IRQ_ADDR_W-1:0]  base,
        input logic [IRQ_ADDR_W-1:0]  code,
        input logic [IRQ_SPACE_W-1:0] space
    );
        logic [IRQ_ADDR_W-1:0] scaled;
        scaled = code * IRQ_ADDR_W'(space);
        return base + scaled;
    endfunction

endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
    parameter int unsigned NUM_LINES = irq_arb_pkg::IRQ_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] pend_q,
    output logic                 any_pend
);
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= lines_in;
    end

    assign any_pend = |pend_q;
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
    parameter int unsigned NUM_LINES = irq_arb_pkg::IRQ_LINES,
    parameter int unsigned SPACE_W   = irq_arb_pkg::IRQ_SPACE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [NUM_LINES-1:0] mask_in,
    input  logic [SPACE_W-1:0]   space_in,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [SPACE_W-1:0]   space_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            space_q <= '0;
        end else if (load) begin
            mask_q  <= mask_in;
            space_q <= space_in;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NUM_LINES = irq_arb_pkg::IRQ_LINES,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] mask,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);
    logic [NUM_LINES-1:0] live;
    assign live = pend & mask;
    assign hit  = |live;

    // Ascending scan: a later (higher) set bit overwrites an earlier one.
    always_comb begin
        idx = '0;
        for (int i = 0; i < int'(NUM_LINES); i++) begin
            if (live[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES = IRQ_LINES,
    parameter int unsigned ADDR_W    = IRQ_ADDR_W,
    parameter int unsigned SPACE_W   = IRQ_SPACE_W,
    parameter int unsigned CODE_BASE = IRQ_CODE_BASE,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               glb_ie,
    input  logic               dbg_mode,
    input  logic               hit,
    input  logic [IDX_W-1:0]   idx_c,
    input  logic [SPACE_W-1:0] space_q,
    input  logic [ADDR_W-1:0]  entry_base,
    output logic               take_q,
    output logic [IDX_W-1:0]   idx_q,
    output logic [ADDR_W-1:0]  vec_q
);
    arb_state_e state_q;
    logic       cond;
    logic       fire;
    logic [ADDR_W-1:0] code;

    assign cond = glb_ie & ~dbg_mode & hit;
    assign fire = cond & (state_q == ARB_IDLE);
    assign code = ADDR_W'(CODE_BASE) + ADDR_W'(idx_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            take_q  <= 1'b0;
            idx_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= cond ? ARB_FIRED : ARB_IDLE;
            take_q  <= fire;
            if (fire) begin
                idx_q <= idx_c;
                vec_q <= vec_target(entry_base, code, space_q);
            end
        end
    end
endmodule

// File: rtl/irq_arbiter_top.sv
module irq_arbiter_top
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES = IRQ_LINES,
    parameter int unsigned REQ_IN_W  = IRQ_IN_W,
    parameter int unsigned ADDR_W    = IRQ_ADDR_W,
    parameter int unsigned SPACE_W   = IRQ_SPACE_W,
    parameter int unsigned CODE_BASE = IRQ_CODE_BASE,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REQ_IN_W-1:0]  req_lines,
    input  logic                 glb_ie,
    input  logic                 dbg_mode,
    input  logic                 cfg_load,
    input  logic [NUM_LINES-1:0] cfg_mask,
    input  logic [SPACE_W-1:0]   cfg_space,
    input  logic [ADDR_W-1:0]    entry_base,
    output logic [NUM_LINES-1:0] pend_bits,
    output logic                 raw_req,
    output logic                 take_pulse,
    output logic [IDX_W-1:0]     win_idx,
    output logic [ADDR_W-1:0]    vec_addr
);
    logic [NUM_LINES-1:0] mask_q;
    logic [SPACE_W-1:0]   space_q;
    logic                 hit;
    logic [IDX_W-1:0]     idx_c;

    irq_pend_capture #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .lines_in (req_lines[NUM_LINES-1:0]),
        .pend_q   (pend_bits),
        .any_pend (raw_req)
    );

    irq_cfg_reg #(.NUM_LINES(NUM_LINES), .SPACE_W(SPACE_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .mask_in  (cfg_mask),
        .space_in (cfg_space),
        .mask_q   (mask_q),
        .space_q  (space_q)
    );

    irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .pend (pend_bits),
        .mask (mask_q),
        .hit  (hit),
        .idx  (idx_c)
    );

    irq_take_ctrl #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .SPACE_W   (SPACE_W),
        .CODE_BASE (CODE_BASE)
    ) u_take (
        .clk        (clk),
        .rst        (rst),
        .glb_ie     (glb_ie),
        .dbg_mode   (dbg_mode),
        .hit        (hit),
        .idx_c      (idx_c),
        .space_q    (space_q),
        .entry_base (entry_base),
        .take_q     (take_pulse),
        .idx_q      (win_idx),
        .vec_q      (vec_addr)
    );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int unsigned NUM_LINES = 13,
    parameter int unsigned REQ_IN_W  = 16,
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned IDX_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [REQ_IN_W-1:0]  req_lines,
    input logic                 glb_ie,
    input logic                 dbg_mode,
    input logic [NUM_LINES-1:0] pend_bits,
    input logic [NUM_LINES-1:0] mask_q,
    input logic                 take_pulse,
    input logic [IDX_W-1:0]     win_idx,
    input logic [ADDR_W-1:0]    vec_addr
);
    p_pend_follow_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pend_bits == $past(req_lines[NUM_LINES-1:0]));

    p_range_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_lines[NUM_LINES-1:0] == '0)
                     && $past(req_lines[REQ_IN_W-1:NUM_LINES] != '0))
        |-> pend_bits == '0);

    p_take_gate_r4: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> $past(glb_ie && !dbg_mode));

    p_take_mask_r5: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> $past((pend_bits & mask_q) != '0));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        take_pulse |=> !take_pulse);

    p_highest_r7: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> ($past(pend_bits & mask_q) >> win_idx) == NUM_LINES'(1));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !take_pulse |-> ($stable(vec_addr) && $stable(win_idx)));
endmodule

bind irq_arbiter_top irq_arbiter_chk #(
    .NUM_LINES (NUM_LINES),
    .REQ_IN_W  (REQ_IN_W),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_lines  (req_lines),
    .glb_ie     (glb_ie),
    .dbg_mode   (dbg_mode),
    .pend_bits  (pend_bits),
    .mask_q     (mask_q),
    .take_pulse (take_pulse),
    .win_idx    (win_idx),
    .vec_addr   (vec_addr)
);

// File: tb/tb_irq_arbiter_top.sv
`timescale 1ns/1ps
module tb_irq_arbiter_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req_lines = '0;
    logic        glb_ie = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        cfg_load = 1'b0;
    logic [12:0] cfg_mask = '0;
    logic [7:0]  cfg_space = '0;
    logic [63:0] entry_base = '0;
    logic [12:0] pend_bits;
    logic        raw_req;
    logic        take_pulse;
    logic [3:0]  win_idx;
    logic [63:0] vec_addr;

    always #4 clk = ~clk;   // 125 MHz

    irq_arbiter_top dut (
        .clk(clk), .rst(rst), .req_lines(req_lines), .glb_ie(glb_ie),
        .dbg_mode(dbg_mode), .cfg_load(cfg_load), .cfg_mask(cfg_mask),
        .cfg_space(cfg_space), .entry_base(entry_base), .pend_bits(pend_bits),
        .raw_req(raw_req), .take_pulse(take_pulse), .win_idx(win_idx),
        .vec_addr(vec_addr)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int          m_pend, m_mask, m_space, m_idx;
    bit          m_take, m_was_on;
    logic [63:0] m_vec;

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_mask = 0; m_space = 0; m_idx = 0;
            m_take = 0; m_was_on = 0; m_vec = '0;
        end else begin
            int  live;
            int  best;
            bit  on;
            live = m_pend & m_mask;
            best = -1;
            for (int i = 0; i < 13; i++) if ((live >> i) & 1) best = i;
            on = glb_ie && !dbg_mode && (best >= 0);
            m_take = on && !m_was_on;
            if (m_take) begin
                m_idx = best;
                m_vec = entry_base + 64'(64 + best) * 64'(m_space);
            end
            m_was_on = on;
            m_pend = int'(req_lines) & 32'h1FFF;
            if (cfg_load) begin
                m_mask  = int'(cfg_mask);
                m_space = int'(cfg_space);
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            cycles++;
            chk("R1 pend_bits model",   64'(pend_bits),  64'(m_pend));
            chk("R3 raw_req model",     64'(raw_req),    64'(m_pend != 0));
            chk("R6 take_pulse model",  64'(take_pulse), 64'(m_take));
            chk("R7 win_idx model",     64'(win_idx),    64'(m_idx));
            chk("R8 vec_addr model",    vec_addr,        m_vec);
            if (cycles > 20000) begin
                bad++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                finished = 1;
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic load_cfg(input logic [12:0] m, input logic [7:0] s);
        cfg_mask = m; cfg_space = s; cfg_load = 1'b1;
        tick(1);
        cfg_load = 1'b0;
    endtask

    task automatic quiet();
        req_lines = '0;
        tick(3);
    endtask

    initial begin
        tick(3);
        chk("R9 reset pend", 64'(pend_bits), 0);
        chk("R9 reset take", 64'(take_pulse), 0);
        chk("R9 reset vec", vec_addr, 0);
        chk("R9 reset idx", 64'(win_idx), 0);
        rst = 1'b0;

        // Reset mask is 0: nothing can be taken.
        glb_ie = 1'b1; req_lines = 16'h0010;
        tick(1);
        chk("R3 raw without mask", 64'(raw_req), 1);
        tick(1);
        chk("R9 mask cleared no take", 64'(take_pulse), 0);
        quiet();

        // R10 load mask and spacing, then single line.
        entry_base = 64'h0000_0000_1000_0000;
        load_cfg(13'h1FFF, 8'd8);
        req_lines = 16'h0008;
        tick(1);
        chk("R1 pend line3", 64'(pend_bits), 64'h8);
        tick(1);
        chk("R10 take after load", 64'(take_pulse), 1);
        chk("R7 idx line3", 64'(win_idx), 3);
        chk("R8 vec line3", vec_addr, 64'h1000_0000 + 64'd67 * 8);
        tick(1);
        chk("R6 pulse drops", 64'(take_pulse), 0);
        tick(5);
        chk("R6 no refire while held", 64'(take_pulse), 0);
        chk("R8 vec held", vec_addr, 64'h1000_0000 + 64'd67 * 8);
        quiet();

        // R2 out-of-range lines only.
        req_lines = 16'hE000;
        tick(1);
        chk("R2 upper bits pend", 64'(pend_bits), 0);
        chk("R2 upper bits raw", 64'(raw_req), 0);
        tick(1);
        chk("R2 upper bits take", 64'(take_pulse), 0);
        quiet();

        // R4 debug mode blocks, then global enable off blocks.
        dbg_mode = 1'b1; req_lines = 16'h0002;
        tick(3);
        chk("R4 debug blocks", 64'(take_pulse), 0);
        quiet();
        dbg_mode = 1'b0; glb_ie = 1'b0; req_lines = 16'h0002;
        tick(3);
        chk("R4 ie off blocks", 64'(take_pulse), 0);
        glb_ie = 1'b1;
        tick(1);
        chk("R4 ie on takes", 64'(take_pulse), 1);
        chk("R7 idx line1", 64'(win_idx), 1);
        quiet();

        // R5 mask excludes the pending line.
        load_cfg(13'h0F00, 8'd4);
        req_lines = 16'h00F0;
        tick(1);
        chk("R5 raw set", 64'(raw_req), 1);
        tick(2);
        chk("R5 masked no take", 64'(take_pulse), 0);
        quiet();

        // R7 several lines, highest wins.
        load_cfg(13'h1FFF, 8'd16);
        req_lines = 16'hF005 | 16'h1000;
        tick(2);
        chk("R7 highest wins", 64'(win_idx), 12);
        chk("R8 vec line12", vec_addr, 64'h1000_0000 + 64'd76 * 16);
        quiet();

        // R8 wrap of the 64-bit sum.
        entry_base = 64'hFFFF_FFFF_FFFF_FF00;
        load_cfg(13'h1FFF, 8'd255);
        req_lines = 16'h1000;
        tick(2);
        chk("R8 vec wraps", vec_addr, 64'h0000_0000_0000_4AB4);
        quiet();

        // Reset in mid-run clears configuration.
        rst = 1'b1; tick(2); rst = 1'b0;
        req_lines = 16'h0100;
        tick(2);
        chk("R9 mask after midrun reset", 64'(take_pulse), 0);
        chk("R9 vec after midrun reset", vec_addr, 0);
        quiet();

        // Random phase against the model.
        for (int n = 0; n < 600; n++) begin
            req_lines  = 16'($urandom);
            glb_ie     = ($urandom_range(0, 7) != 0);
            dbg_mode   = ($urandom_range(0, 7) == 0);
            cfg_load   = ($urandom_range(0, 9) == 0);
            cfg_mask   = 13'($urandom);
            cfg_space  = 8'($urandom);
            entry_base = {32'($urandom), 32'($urandom)};
            tick($urandom_range(1, 3));
        end
        cfg_load = 1'b0;
        tick(2);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule